// File: doc/BRIEF.md
# Weight Tile Staging FIFO

This block is a queue of complete weight tiles between the memory-read path and a systolic multiply array. The memory side pushes one tile row per accepted beat. The array side pops rows of the oldest complete tile, one row per request, and loads them into its background weight buffer. Because tiles are fetched while the array works on an earlier tile, the queue lets weight traffic overlap with compute.

Occupancy is counted in whole tiles, not in rows. A tile becomes visible to the reader only when its final row has been written. A tile slot is taken from the first written row until the final row has been read. When no complete tile is waiting, the block raises a stall to the array. A flush input drops every staged tile and any partly written tile in one cycle.

The geometry is set by parameters: the row width in bits, the rows per tile and the number of tile slots (four by default). Read data is first-word-fall-through: the head row is presented whenever a complete tile is available.

Top module: `wt_stage_fifo`

## Requirements
- R1: Out of reset, wr_ready_o=1, rd_valid_o=0, tiles_avail_o=0, full_o=0 and stall_o=1.
- R2: While rows 0 to ROWS_PER_TILE-2 of a tile are being written, tiles_avail_o and rd_valid_o do not change because of that tile. The edge that accepts its last row raises tiles_avail_o by one, and rd_valid_o is 1 after that edge.
- R3: Rows leave in the order they were written, and tiles leave in the order they were completed. rd_last_o is 1 exactly when the presented row is row ROWS_PER_TILE-1 of its tile.
- R4: A tile slot counts as taken from the acceptance of the tile's first row until the read of its last row. wr_ready_o is 0 while all NUM_TILES slots are taken and no tile is partly written. A beat offered while wr_ready_o=0 is discarded.
- R5: The edge that accepts a read of a tile's last row lowers tiles_avail_o by one and frees that tile's slot. A blocked writer sees wr_ready_o=1 after that edge.
- R6: stall_o is 1 exactly when tiles_avail_o is 0, and rd_valid_o is then 0.
- R7: flush_i=1 at an edge discards all complete and partial tiles. After that edge, tiles_avail_o=0, full_o=0, wr_ready_o=1, and the next tile written is the next tile read.
- R8: If the last row of one tile is written and the last row of another tile is read in the same cycle, tiles_avail_o is unchanged.
- R9: rd_req_i while rd_valid_o=0 has no effect: the next tile completed is read starting from its row 0.
- R10: full_o is 1 while all NUM_TILES slots are taken, including a partly written tile. It is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flush_i | input | 1 | Discard all staged and partial tiles |
| wr_valid_i | input | 1 | Memory side offers a row |
| wr_data_i | input | ROW_W | Row data from memory |
| wr_ready_o | output | 1 | Row can be accepted |
| rd_req_i | input | 1 | Array pops the head row |
| rd_valid_o | output | 1 | A complete tile is at the head |
| rd_data_o | output | ROW_W | Head row data |
| rd_last_o | output | 1 | Head row is the last row of its tile |
| tiles_avail_o | output | CNT_W | Number of complete tiles staged |
| full_o | output | 1 | All tile slots taken |
| stall_o | output | 1 | No complete tile: the array must stall |

## Verification
The hardest situation to reach is a single cycle in which one tile completes on the write side while another tile finishes on the read side. Reaching it needs two tiles in flight at once. The stimulus writes one whole tile, writes all but the last row of a second tile, and drains all but the last row of the first. It then drives the final write and the final read together. A second hard case is full_o with wr_ready_o still high. This occurs when three tiles are complete and a fourth is only partly written. It is reached by stopping the write stream after one row of the fourth tile.

// File: rtl/wt_stage_pkg.sv
package wt_stage_pkg;
  parameter int unsigned WTS_ROW_W     = 32;
  parameter int unsigned WTS_ROWS      = 4;
  parameter int unsigned WTS_NUM_TILES = 4;

  function automatic int unsigned wts_aw(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/wts_tile_ptr.sv
module wts_tile_ptr #(
  parameter int unsigned ROWS   = 4,
  parameter int unsigned TILES  = 4,
  parameter int unsigned ROW_AW = 2,
  parameter int unsigned TILE_AW = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clr_i,
  input  logic               adv_i,
  output logic [ROW_AW-1:0]  row_o,
  output logic [TILE_AW-1:0] tile_o,
  output logic               first_o,
  output logic               last_o
);
  assign first_o = (row_o == '0);
  assign last_o  = (row_o == ROW_AW'(ROWS - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      row_o  <= '0;
      tile_o <= '0;
    end else if (clr_i) begin
      row_o  <= '0;
      tile_o <= '0;
    end else if (adv_i) begin
      if (last_o) begin
        row_o  <= '0;
        tile_o <= (tile_o == TILE_AW'(TILES - 1)) ? '0 : tile_o + 1'b1;
      end else begin
        row_o <= row_o + 1'b1;
      end
    end
  end
endmodule

// File: rtl/wts_tile_store.sv
module wts_tile_store #(
  parameter int unsigned ROW_W = 32,
  parameter int unsigned DEPTH = 16,
  parameter int unsigned AW    = 4
) (
  input  logic             clk_i,
  input  logic             we_i,
  input  logic [AW-1:0]    waddr_i,
  input  logic [ROW_W-1:0] wdata_i,
  input  logic [AW-1:0]    raddr_i,
  output logic [ROW_W-1:0] rdata_o
);
  logic [ROW_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/wts_occupancy.sv
module wts_occupancy #(
  parameter int unsigned CW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          start_i,
  input  logic          wr_done_i,
  input  logic          rd_done_i,
  output logic [CW-1:0] used_o,
  output logic [CW-1:0] avail_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      used_o  <= '0;
      avail_o <= '0;
    end else if (clr_i) begin
      used_o  <= '0;
      avail_o <= '0;
    end else begin
      unique case ({start_i, rd_done_i})
        2'b10:   used_o <= used_o + 1'b1;
        2'b01:   used_o <= used_o - 1'b1;
        default: used_o <= used_o;
      endcase
      unique case ({wr_done_i, rd_done_i})
        2'b10:   avail_o <= avail_o + 1'b1;
        2'b01:   avail_o <= avail_o - 1'b1;
        default: avail_o <= avail_o;
      endcase
    end
  end
endmodule

// File: rtl/wt_stage_fifo.sv
module wt_stage_fifo
  import wt_stage_pkg::*;
#(
  parameter int unsigned ROW_W         = WTS_ROW_W,
  parameter int unsigned ROWS_PER_TILE = WTS_ROWS,
  parameter int unsigned NUM_TILES     = WTS_NUM_TILES,
  localparam int unsigned CNT_W        = $clog2(NUM_TILES + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             wr_valid_i,
  input  logic [ROW_W-1:0] wr_data_i,
  output logic             wr_ready_o,
  input  logic             rd_req_i,
  output logic             rd_valid_o,
  output logic [ROW_W-1:0] rd_data_o,
  output logic             rd_last_o,
  output logic [CNT_W-1:0] tiles_avail_o,
  output logic             full_o,
  output logic             stall_o
);
  localparam int unsigned ROW_AW  = wts_aw(ROWS_PER_TILE);
  localparam int unsigned TILE_AW = wts_aw(NUM_TILES);
  localparam int unsigned DEPTH   = NUM_TILES * ROWS_PER_TILE;
  localparam int unsigned AW      = wts_aw(DEPTH);

  logic [ROW_AW-1:0]  wr_row, rd_row;
  logic [TILE_AW-1:0] wr_tile, rd_tile;
  logic               wr_first, wr_last, rd_first, rd_last;
  logic [CNT_W-1:0]   used;
  logic               wr_fire, rd_fire;
  logic [AW-1:0]      waddr, raddr;

  // a partial tile already holds its slot, so it may always finish
  assign wr_ready_o = !wr_first || (used < CNT_W'(NUM_TILES));
  assign wr_fire    = wr_valid_i && wr_ready_o && !flush_i;
  assign rd_valid_o = (tiles_avail_o != '0);
  assign rd_fire    = rd_req_i && rd_valid_o && !flush_i;

  assign waddr = AW'(wr_tile) * AW'(ROWS_PER_TILE) + AW'(wr_row);
  assign raddr = AW'(rd_tile) * AW'(ROWS_PER_TILE) + AW'(rd_row);

  wts_tile_ptr #(
    .ROWS(ROWS_PER_TILE), .TILES(NUM_TILES), .ROW_AW(ROW_AW), .TILE_AW(TILE_AW)
  ) u_wr_ptr (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(flush_i), .adv_i(wr_fire),
    .row_o(wr_row), .tile_o(wr_tile), .first_o(wr_first), .last_o(wr_last)
  );

  wts_tile_ptr #(
    .ROWS(ROWS_PER_TILE), .TILES(NUM_TILES), .ROW_AW(ROW_AW), .TILE_AW(TILE_AW)
  ) u_rd_ptr (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(flush_i), .adv_i(rd_fire),
    .row_o(rd_row), .tile_o(rd_tile), .first_o(rd_first), .last_o(rd_last)
  );

  wts_tile_store #(.ROW_W(ROW_W), .DEPTH(DEPTH), .AW(AW)) u_store (
    .clk_i(clk_i), .we_i(wr_fire), .waddr_i(waddr), .wdata_i(wr_data_i),
    .raddr_i(raddr), .rdata_o(rd_data_o)
  );

  wts_occupancy #(.CW(CNT_W)) u_occ (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(flush_i),
    .start_i(wr_fire && wr_first),
    .wr_done_i(wr_fire && wr_last),
    .rd_done_i(rd_fire && rd_last),
    .used_o(used), .avail_o(tiles_avail_o)
  );

  assign rd_last_o = rd_last;
  assign full_o    = (used == CNT_W'(NUM_TILES));
  assign stall_o   = !rd_valid_o;

  logic unused_rd_first;
  assign unused_rd_first = rd_first;
endmodule

// File: rtl/wt_stage_fifo_chk.sv
module wt_stage_fifo_chk #(
  parameter int unsigned NUM_TILES = 4,
  parameter int unsigned CNT_W     = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             flush_i,
  input logic             wr_ready_o,
  input logic             rd_valid_o,
  input logic [CNT_W-1:0] tiles_avail_o,
  input logic             full_o,
  input logic             stall_o
);
  AST_AVAIL_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tiles_avail_o <= CNT_W'(NUM_TILES)); // R4

  AST_FLUSH_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (tiles_avail_o == '0) && !rd_valid_o && wr_ready_o && !full_o); // R7

  AST_AVAIL_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flush_i |=> (tiles_avail_o == $past(tiles_avail_o))
              || (tiles_avail_o == $past(tiles_avail_o) + 1'b1)
              || (tiles_avail_o == $past(tiles_avail_o) - 1'b1)); // R2

  AST_FULL_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && (tiles_avail_o == CNT_W'(NUM_TILES))) |-> !wr_ready_o); // R10

  AST_STALL_NO_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |-> !rd_valid_o && (tiles_avail_o == '0)); // R6
endmodule

bind wt_stage_fifo wt_stage_fifo_chk #(.NUM_TILES(NUM_TILES), .CNT_W(CNT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .flush_i(flush_i), .wr_ready_o(wr_ready_o),
  .rd_valid_o(rd_valid_o), .tiles_avail_o(tiles_avail_o), .full_o(full_o),
  .stall_o(stall_o)
);

// File: tb/wt_stage_fifo_bench.sv
module wt_stage_fifo_bench;
  localparam int unsigned W  = 16;
  localparam int unsigned RP = 4;
  localparam int unsigned NT = 4;
  localparam int unsigned CW = $clog2(NT + 1);

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic flush = 1'b0, wr_valid = 1'b0, rd_req = 1'b0;
  logic [W-1:0] wr_data = '0;
  logic wr_ready, rd_valid, rd_last, full, stall;
  logic [W-1:0] rd_data;
  logic [CW-1:0] avail;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  wt_stage_fifo #(.ROW_W(W), .ROWS_PER_TILE(RP), .NUM_TILES(NT)) u_wt_stage_fifo (
    .clk_i(clk), .rst_ni(rst_ni), .flush_i(flush), .wr_valid_i(wr_valid),
    .wr_data_i(wr_data), .wr_ready_o(wr_ready), .rd_req_i(rd_req),
    .rd_valid_o(rd_valid), .rd_data_o(rd_data), .rd_last_o(rd_last),
    .tiles_avail_o(avail), .full_o(full), .stall_o(stall)
  );

  function automatic logic [W-1:0] pat(input int s, input int t, input int r);
    return W'(s * 256 + t * 16 + r);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk); #1;
  endtask

  task automatic push(input logic [W-1:0] d);
    wr_valid = 1'b1; wr_data = d;
    cyc();
    wr_valid = 1'b0;
  endtask

  task automatic push_tile(input int s, input int t);
    for (int r = 0; r < RP; r++) push(pat(s, t, r));
  endtask

  task automatic pop_tile(input int s, input int t);
    for (int r = 0; r < RP; r++) begin
      check("R3 valid", 32'(rd_valid), 32'd1);
      check("R3 data", 32'(rd_data), 32'(pat(s, t, r)));
      check("R3 last", 32'(rd_last), 32'(r == RP - 1));
      rd_req = 1'b1;
      cyc();
      rd_req = 1'b0;
    end
  endtask

  task automatic t_reset();
    check("R1 wr_ready", 32'(wr_ready), 32'd1);
    check("R1 rd_valid", 32'(rd_valid), 32'd0);
    check("R1 avail", 32'(avail), 32'd0);
    check("R1 full", 32'(full), 32'd0);
    check("R1 stall", 32'(stall), 32'd1);
  endtask

  task automatic t_visibility();
    for (int r = 0; r < RP - 1; r++) begin
      push(pat(1, 0, r));
      check("R2 avail partial", 32'(avail), 32'd0);
      check("R2 rd_valid partial", 32'(rd_valid), 32'd0);
      check("R6 stall partial", 32'(stall), 32'd1);
    end
    push(pat(1, 0, RP - 1));
    check("R2 avail complete", 32'(avail), 32'd1);
    check("R2 rd_valid complete", 32'(rd_valid), 32'd1);
    check("R6 stall complete", 32'(stall), 32'd0);
    pop_tile(1, 0);
    check("R5 avail drained", 32'(avail), 32'd0);
    check("R6 stall drained", 32'(stall), 32'd1);
  endtask

  task automatic t_fill();
    for (int t = 0; t < NT - 1; t++) push_tile(2, t);
    push(pat(2, NT - 1, 0));
    check("R10 full with partial", 32'(full), 32'd1);
    check("R4 ready with partial", 32'(wr_ready), 32'd1);
    check("R2 avail with partial", 32'(avail), 32'(NT - 1));
    for (int r = 1; r < RP; r++) push(pat(2, NT - 1, r));
    check("R4 avail at capacity", 32'(avail), 32'(NT));
    check("R4 ready at capacity", 32'(wr_ready), 32'd0);
    push(16'hdead);
    check("R4 avail after blocked beat", 32'(avail), 32'(NT));
    pop_tile(2, 0);
    check("R5 ready after free", 32'(wr_ready), 32'd1);
    check("R5 avail after free", 32'(avail), 32'(NT - 1));
    check("R10 full after free", 32'(full), 32'd0);
    for (int t = 1; t < NT; t++) pop_tile(2, t);
    check("R5 avail empty", 32'(avail), 32'd0);
  endtask

  task automatic t_ignored_read();
    rd_req = 1'b1;
    cyc();
    rd_req = 1'b0;
    check("R9 avail", 32'(avail), 32'd0);
    push_tile(5, 1);
    pop_tile(5, 1);
  endtask

  task automatic t_concurrent();
    push_tile(3, 0);
    for (int r = 0; r < RP - 1; r++) push(pat(3, 1, r));
    for (int r = 0; r < RP - 1; r++) begin
      check("R8 data pre", 32'(rd_data), 32'(pat(3, 0, r)));
      rd_req = 1'b1; cyc(); rd_req = 1'b0;
    end
    check("R8 last pre", 32'(rd_last), 32'd1);
    check("R8 data last", 32'(rd_data), 32'(pat(3, 0, RP - 1)));
    wr_valid = 1'b1; wr_data = pat(3, 1, RP - 1); rd_req = 1'b1;
    cyc();
    wr_valid = 1'b0; rd_req = 1'b0;
    check("R8 avail unchanged", 32'(avail), 32'd1);
    pop_tile(3, 1);
  endtask

  task automatic t_flush();
    push_tile(6, 0);
    push(pat(6, 1, 0));
    push(pat(6, 1, 1));
    flush = 1'b1; cyc(); flush = 1'b0;
    check("R7 avail", 32'(avail), 32'd0);
    check("R7 stall", 32'(stall), 32'd1);
    check("R7 rd_valid", 32'(rd_valid), 32'd0);
    check("R7 wr_ready", 32'(wr_ready), 32'd1);
    check("R7 full", 32'(full), 32'd0);
    push_tile(7, 2);
    check("R7 avail new", 32'(avail), 32'd1);
    pop_tile(7, 2);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_ni = 1'b1;
    cyc();
    t_reset();
    t_visibility();
    t_fill();
    t_ignored_read();
    t_concurrent();
    t_flush();
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL WDOG: actual=timeout expected=completion");
      summary();
      $finish;
    end
  end
endmodule